// File: doc/BRIEF.md
# Low-Power Cyclic Sense and Forced Wake Timer

This block keeps time while the device sits in a low-power state and decides when to ask for a wake-up. It has two uses, and only one can be active at a time. In cyclic-sense mode it counts out a programmed interval and then powers the selected high-side switch outputs for a short settle window. At the end of that window it samples the wake input and compares the sample with the one taken at the end of the previous window. If the two differ, it raises a wake request. In forced-wake mode it counts out the programmed interval once and raises a single wake request. No switch output is driven in this mode.

The control fields come in as levels: the two mode requests, a 3-bit period code, the per-switch enables and the wake-input enable. A small arbiter turns the two mode requests into one granted mode. Once a mode is granted, a request for the other mode is refused until the granted mode is released. The timer runs only while the low-power flag is high and a mode is granted. Dropping the flag clears the timer, including the reference sample.

Top module: `lp_wake_timer`

## Requirements
- R1: After reset, `mode_o` is 00 (no mode), `sw_drive` is all zero and `wake_req` is low.
- R2: From no mode, cyclic sense (`mode_o` = 01) is granted only when `cyc_req` and `wake_in_en` are high and `frc_req` is low. Forced wake (`mode_o` = 10) is granted only when `frc_req` is high, `cyc_req` is low and every bit of `sw_en` is zero. The grant appears one clock after the request is seen.
- R3: While cyclic sense is granted, `frc_req` is ignored. While forced wake is granted, `cyc_req` is ignored. Requesting both modes together from no mode grants neither. A granted mode falls back to 00 when its own request drops, and cyclic sense also falls back when `wake_in_en` drops.
- R4: The wait interval is BASE_CYC << `period_code` clocks, where `period_code` is a 3-bit code (default BASE_CYC = 8, giving 8 to 1024 clocks).
- R5: In cyclic sense, each wait interval is followed by SETTLE_CYC clocks (default 4) during which `sw_drive` equals `sw_en`. `sw_drive` is zero at all other times, so a full cycle lasts wait plus settle clocks.
- R6: In cyclic sense, `wake_in` is sampled on the last clock of each settle window. A wake is requested when the sample differs from the previous sample. The first sample after the timer starts only sets the reference. Changes of `wake_in` that revert between samples are not seen.
- R7: In forced wake, exactly one wake request is raised, one wait interval after the timer starts. Nothing further is raised while low power continues, and `sw_drive` stays zero.
- R8: When `lp_active` is low, the timer is held cleared: no wake request, no switch drive, the count restarts, and the reference sample is forgotten.
- R9: `wake_req` is a pulse exactly one clock wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_req | input | 1 | Request for cyclic-sense mode |
| frc_req | input | 1 | Request for forced-wake mode |
| wake_in_en | input | 1 | Wake input enabled for sensing |
| sw_en | input | NUM_SW | Per-switch enable for cyclic-sense drive |
| period_code | input | 3 | Wait interval selector |
| lp_active | input | 1 | Device is in a low-power state |
| wake_in | input | 1 | Wake input level |
| sw_drive | output | NUM_SW | High-side switch drive |
| wake_req | output | 1 | One-clock wake request |
| mode_o | output | 2 | Granted mode: 00 none, 01 cyclic sense, 10 forced wake |

## Verification
The properties assume that every input is a synchronous level that is stable around each rising edge, and that `period_code` and `sw_en` do not change while the timer is running. The exclusivity and grant properties also assume that the mode requests are the only route into a mode.

The bench changes inputs only at falling edges. It reprograms the period code and the switch enables only while `lp_active` is low. It compares outputs clock by clock against a model of the wait and settle schedule. In that schedule, `wake_in` toggles, holds, and glitches between sample points.

// File: rtl/lpwt_pkg.sv
package lpwt_pkg;
    localparam int CODE_W = 3;

    typedef enum logic [1:0] {
        MODE_NONE = 2'b00,
        MODE_CYC  = 2'b01,
        MODE_FRC  = 2'b10
    } wake_mode_e;

    typedef enum logic [1:0] {
        PH_WAIT   = 2'b00,
        PH_SETTLE = 2'b01,
        PH_DONE   = 2'b10
    } seq_phase_e;

    typedef struct packed {
        logic cyc;
        logic frc;
        logic in_en;
        logic sw_any;
    } mode_req_t;

    typedef struct packed {
        seq_phase_e phase;
        logic       have_ref;
        logic       ref_lvl;
    } seq_state_t;

    function automatic int unsigned period_cycles(input int unsigned base,
                                                  input logic [CODE_W-1:0] code);
        return base << code;
    endfunction
endpackage

// File: rtl/lpwt_mode_arb.sv
module lpwt_mode_arb
    import lpwt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  mode_req_t  req,
    output wake_mode_e mode
);
    wake_mode_e mode_nx;

    always_comb begin
        mode_nx = mode;
        unique case (mode)
            MODE_NONE: begin
                if (req.cyc && !req.frc && req.in_en)
                    mode_nx = MODE_CYC;
                else if (req.frc && !req.cyc && !req.sw_any)
                    mode_nx = MODE_FRC;
            end
            MODE_CYC: if (!req.cyc || !req.in_en) mode_nx = MODE_NONE;
            MODE_FRC: if (!req.frc) mode_nx = MODE_NONE;
            default:  mode_nx = MODE_NONE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) mode <= MODE_NONE;
        else     mode <= mode_nx;
    end
endmodule

// File: rtl/lpwt_seq.sv
module lpwt_seq
    import lpwt_pkg::*;
#(
    parameter int NUM_SW     = 2,
    parameter int BASE_CYC   = 8,
    parameter int SETTLE_CYC = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  wake_mode_e        mode,
    input  logic [CODE_W-1:0] period_code,
    input  logic [NUM_SW-1:0] sw_en,
    input  logic              lp_active,
    input  logic              wake_in,
    output logic [NUM_SW-1:0] sw_drive,
    output logic              wake_req
);
    localparam int MAX_PERIOD = BASE_CYC << ((1 << CODE_W) - 1);
    localparam int MAX_COUNT  = (MAX_PERIOD > SETTLE_CYC) ? MAX_PERIOD : SETTLE_CYC;
    localparam int CNT_W      = $clog2(MAX_COUNT + 1);
    localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_CYC - 1);

    seq_state_t       st;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] wait_last;
    logic             run;
    logic             drive_on;

    assign run       = lp_active && (mode != MODE_NONE);
    assign wait_last = CNT_W'(period_cycles(BASE_CYC, period_code) - 1);
    assign drive_on  = run && (mode == MODE_CYC) && (st.phase == PH_SETTLE);

    for (genvar i = 0; i < NUM_SW; i++) begin : g_drive
        assign sw_drive[i] = drive_on & sw_en[i];
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt         <= '0;
            st.phase    <= PH_WAIT;
            st.have_ref <= 1'b0;
            st.ref_lvl  <= 1'b0;
            wake_req    <= 1'b0;
        end else begin
            wake_req <= 1'b0;
            unique case (st.phase)
                PH_WAIT: begin
                    if (cnt >= wait_last) begin
                        cnt <= '0;
                        if (mode == MODE_CYC) begin
                            st.phase <= PH_SETTLE;
                        end else begin
                            st.phase <= PH_DONE;
                            wake_req <= 1'b1;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_SETTLE: begin
                    if (cnt >= SETTLE_LAST) begin
                        cnt         <= '0;
                        st.phase    <= PH_WAIT;
                        st.have_ref <= 1'b1;
                        st.ref_lvl  <= wake_in;
                        if (st.have_ref && (st.ref_lvl != wake_in))
                            wake_req <= 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: st.phase <= PH_DONE;
            endcase
        end
    end
endmodule

// File: rtl/lp_wake_timer.sv
module lp_wake_timer
    import lpwt_pkg::*;
#(
    parameter int NUM_SW     = 2,
    parameter int BASE_CYC   = 8,
    parameter int SETTLE_CYC = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cyc_req,
    input  logic              frc_req,
    input  logic              wake_in_en,
    input  logic [NUM_SW-1:0] sw_en,
    input  logic [CODE_W-1:0] period_code,
    input  logic              lp_active,
    input  logic              wake_in,
    output logic [NUM_SW-1:0] sw_drive,
    output logic              wake_req,
    output logic [1:0]        mode_o
);
    mode_req_t  req;
    wake_mode_e mode;

    assign req.cyc    = cyc_req;
    assign req.frc    = frc_req;
    assign req.in_en  = wake_in_en;
    assign req.sw_any = |sw_en;
    assign mode_o     = mode;

    lpwt_mode_arb u_arb (
        .clk  (clk),
        .rst  (rst),
        .req  (req),
        .mode (mode)
    );

    lpwt_seq #(
        .NUM_SW     (NUM_SW),
        .BASE_CYC   (BASE_CYC),
        .SETTLE_CYC (SETTLE_CYC)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .mode        (mode),
        .period_code (period_code),
        .sw_en       (sw_en),
        .lp_active   (lp_active),
        .wake_in     (wake_in),
        .sw_drive    (sw_drive),
        .wake_req    (wake_req)
    );
endmodule

// File: rtl/lpwt_checker.sv
module lpwt_checker #(
    parameter int NUM_SW = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              cyc_req,
    input logic              frc_req,
    input logic              wake_in_en,
    input logic [NUM_SW-1:0] sw_en,
    input logic              lp_active,
    input logic [NUM_SW-1:0] sw_drive,
    input logic              wake_req,
    input logic [1:0]        mode_o
);
    a_r1_wake_needs_lp: assert property (@(posedge clk) disable iff (rst)
        wake_req |-> $past(lp_active));

    a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst)
        wake_req |=> !wake_req);

    a_r7_forced_no_drive: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 2'b10) |-> (sw_drive == '0));

    a_r5_drive_within_enable: assert property (@(posedge clk) disable iff (rst)
        (sw_drive & ~sw_en) == '0);

    a_r3_cyc_holds: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 2'b01 && cyc_req && wake_in_en) |=> (mode_o == 2'b01));

    a_r3_frc_holds: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 2'b10 && frc_req) |=> (mode_o == 2'b10));

    a_r2_frc_refused: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 2'b00 && sw_en != '0) |=> (mode_o != 2'b10));

    a_r8_lp_low_quiet: assert property (@(posedge clk) disable iff (rst)
        !lp_active |=> (!wake_req && sw_drive == '0));
endmodule

bind lp_wake_timer lpwt_checker #(.NUM_SW(NUM_SW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cyc_req    (cyc_req),
    .frc_req    (frc_req),
    .wake_in_en (wake_in_en),
    .sw_en      (sw_en),
    .lp_active  (lp_active),
    .sw_drive   (sw_drive),
    .wake_req   (wake_req),
    .mode_o     (mode_o)
);

// File: tb/lp_wake_timer_tb.sv
`timescale 1ns/1ps
module lp_wake_timer_tb;
    localparam int NUM_SW     = 2;
    localparam int BASE_CYC   = 8;
    localparam int SETTLE_CYC = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cyc_req = 1'b0, frc_req = 1'b0, wake_in_en = 1'b0;
    logic [NUM_SW-1:0] sw_en = '0;
    logic [2:0]        period_code = '0;
    logic              lp_active = 1'b0, wake_in = 1'b0;
    logic [NUM_SW-1:0] sw_drive;
    logic              wake_req;
    logic [1:0]        mode_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    lp_wake_timer #(.NUM_SW(NUM_SW), .BASE_CYC(BASE_CYC), .SETTLE_CYC(SETTLE_CYC)) u_dut (
        .clk(clk), .rst(rst), .cyc_req(cyc_req), .frc_req(frc_req),
        .wake_in_en(wake_in_en), .sw_en(sw_en), .period_code(period_code),
        .lp_active(lp_active), .wake_in(wake_in), .sw_drive(sw_drive),
        .wake_req(wake_req), .mode_o(mode_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        step();
        step();
        rst = 1'b0;
        chk("R1", "mode after reset", mode_o, 0);
        chk("R1", "drive after reset", sw_drive, 0);
        chk("R1", "wake after reset", wake_req, 0);
    endtask

    task automatic t_grant();
        cyc_req = 1; wake_in_en = 0; step();
        chk("R2", "cyclic refused without input enable", mode_o, 0);
        wake_in_en = 1; step();
        chk("R2", "cyclic granted", mode_o, 1);
        frc_req = 1; step();
        chk("R3", "forced request ignored in cyclic", mode_o, 1);
        cyc_req = 0; step();
        chk("R3", "cyclic released", mode_o, 0);
        step();
        chk("R2", "forced granted with switches off", mode_o, 2);
        cyc_req = 1; step();
        chk("R3", "cyclic request ignored in forced", mode_o, 2);
        cyc_req = 0; frc_req = 0; step();
        chk("R3", "forced released", mode_o, 0);
        cyc_req = 1; frc_req = 1; step();
        chk("R3", "both requested grants none", mode_o, 0);
        cyc_req = 0; sw_en = 2'b01; step();
        chk("R2", "forced refused with a switch enabled", mode_o, 0);
        sw_en = 2'b00; step();
        chk("R2", "forced granted after switches cleared", mode_o, 2);
        frc_req = 0; wake_in_en = 0; step();
        chk("R3", "idle after release", mode_o, 0);
    endtask

    task automatic run_fw(input int code, input int n_total);
        int p;
        int bad_w;
        int bad_d;
        p = BASE_CYC << code;
        bad_w = 0;
        bad_d = 0;
        period_code = code[2:0]; sw_en = '0; frc_req = 1; step();
        chk("R7", "forced mode granted", mode_o, 2);
        lp_active = 1;
        for (int n = 1; n <= n_total; n++) begin
            step();
            checks++;
            if (wake_req != (n == p)) begin
                errors++; bad_w++;
                $display("FAIL R4 R7 forced wake after edge %0d: actual %0d expected %0d", n, wake_req, (n == p));
            end
            checks++;
            if (sw_drive != '0) begin
                errors++; bad_d++;
                $display("FAIL R7 forced drive: actual %0d expected 0", sw_drive);
            end
        end
        lp_active = 0; frc_req = 0; step();
        chk("R8", "wake quiet after low power ends", wake_req, 0);
        chk("R7", "no late mismatches in forced run", bad_w + bad_d, 0);
    endtask

    function automatic logic lvl_at(input int n, input logic start, input int t1, input int t2,
                                    input int g0, input int g1);
        return start ^ (n >= t1) ^ (n >= t2) ^ ((n >= g0) && (n < g1));
    endfunction

    task automatic run_cs(input int code, input logic [NUM_SW-1:0] en, input int n_total,
                          input logic start, input int t1, input int t2, input int g0, input int g1);
        int p;
        int len;
        logic have_ref;
        logic ref_lvl;
        logic exp_w;
        logic [NUM_SW-1:0] exp_d;
        p = BASE_CYC << code;
        len = p + SETTLE_CYC;
        have_ref = 0;
        ref_lvl = 0;
        period_code = code[2:0]; sw_en = en; wake_in_en = 1; cyc_req = 1; step();
        chk("R2", "cyclic granted for run", mode_o, 1);
        lp_active = 1;
        for (int n = 1; n <= n_total; n++) begin
            wake_in = lvl_at(n, start, t1, t2, g0, g1);
            step();
            exp_d = ((n % len) >= p) ? en : '0;
            exp_w = 0;
            if ((n % len) == 0) begin
                exp_w = have_ref && (ref_lvl != wake_in);
                have_ref = 1;
                ref_lvl = wake_in;
            end
            checks++;
            if (sw_drive != exp_d) begin
                errors++;
                $display("FAIL R5 drive after edge %0d: actual %0d expected %0d", n, sw_drive, exp_d);
            end
            checks++;
            if (wake_req != exp_w) begin
                errors++;
                $display("FAIL R6 wake after edge %0d: actual %0d expected %0d", n, wake_req, exp_w);
            end
        end
    endtask

    task automatic t_cyclic_basic();
        // R6: first sample at 12 is reference only; change at 20 woken at 24;
        // change at 40 woken at 48; glitch 50..52 not seen at 60.
        run_cs(0, 2'b01, 72, 1'b1, 20, 40, 50, 53);
        lp_active = 0; cyc_req = 0; wake_in_en = 0; step();
        chk("R8", "drive off after low power ends", sw_drive, 0);
    endtask

    task automatic t_lp_clear();
        run_cs(0, 2'b10, 30, 1'b1, 1000, 1000, 1000, 1000);
        lp_active = 0; step();
        chk("R8", "wake cleared when low power drops", wake_req, 0);
        chk("R8", "drive cleared when low power drops", sw_drive, 0);
        cyc_req = 0; step();
        // R8: restart with the opposite level; the first sample must not wake.
        run_cs(1, 2'b11, 60, 1'b0, 30, 1000, 1000, 1000);
        lp_active = 0; cyc_req = 0; wake_in_en = 0; step();
        chk("R8", "idle mode after cyclic run", mode_o, 0);
    endtask

    task automatic t_forced();
        run_fw(1, 120);
        run_fw(3, 140);
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_grant();
        t_forced();
        t_cyclic_basic();
        t_lp_clear();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule